// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that completes each instruction in one clock cycle. It runs a small subset: register add, add-immediate, signed set-less-than-immediate, word load and word store. In one cycle the core does five things. It fetches a word at the program counter and decodes the opcode, which fixes the field layout. It reads the source registers and computes a sum or a signed compare. It reads or writes data memory. At the rising edge it commits the result to the register file and advances the program counter by four.

The core holds the program counter, a 32-entry register file, a word-organised instruction memory and a word-organised data memory. A controller drives the multiplexer selects: register or immediate operand, destination field, and ALU or memory result. Instruction memory is filled through a load port while reset is held. Register and memory contents are read combinationally through two debug ports. Nothing branches or jumps, so the program counter only counts upward and wraps at the end of instruction memory.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high on a rising edge, the program counter, all 32 registers and every data memory word are cleared to zero. The debug ports then read zero.
- R2: With `rst` low, every rising edge adds 4 to the program counter. The instruction word used is at index `pc[IA_W+1:2]`.
- R3: A word with opcode bits[31:26] = 0x00 and function bits[5:0] = 0x20 writes rs + rt, modulo 2^32, to rd. The fields are rs = bits[25:21], rt = bits[20:16] and rd = bits[15:11].
- R4: Opcode 0x08 writes rs plus the sign-extended 16-bit immediate (bits[15:0]) to rt.
- R5: Opcode 0x0A writes 1 to rt when rs is less than the sign-extended immediate as a signed number, and writes 0 otherwise.
- R6: Opcode 0x23 loads the data word at byte address rs + sign-extended immediate into rt. The word index is address bits[DA_W+1:2].
- R7: Opcode 0x2B stores rt to the data word at byte address rs + sign-extended immediate and changes no register.
- R8: Register 0 always reads zero. An instruction that names it as destination leaves it zero.
- R9: Any other opcode, or opcode 0x00 with a function code other than 0x20, writes no register and no memory. The program counter still advances by 4.
- R10: A rising edge with `ld_en` high stores `ld_data` at instruction index `ld_addr`, and the stored words are the ones executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Instruction memory write strobe |
| ld_addr | input | IA_W | Instruction memory word index to write |
| ld_data | input | 32 | Instruction word to write |
| dbg_reg_sel | input | 5 | Register index for the debug read |
| dbg_reg_val | output | 32 | Content of the selected register |
| dbg_mem_sel | input | DA_W | Data memory word index for the debug read |
| dbg_mem_val | output | 32 | Content of the selected data word |
| pc | output | 32 | Current program counter |

## Verification
The bench runs a generated program and tracks it with an arithmetic model of registers and memory. It compares the destination register or stored word after each instruction. It makes a full sweep after every unsupported encoding and at the end. The program compares a negative register against zero and against a negative immediate. An unsigned compare would write 0 where 1 is due. It uses the extreme immediates 32767 and -32768, so a core that zero-extends shows the wrong sums. It also forms addresses from negative offsets and overwrites a stored word before loading it back, which catches a wrong address or a stale read. Writes aimed at register 0 catch a core that stores into it. Encodings with an unknown opcode or function catch a decoder that lets them write anything.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] FN_ADD   = 6'h20;

    typedef enum logic [0:0] {
        ALU_ADD = 1'b0,
        ALU_SLT = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic    legal;
        logic    reg_we;
        logic    dst_is_rd;
        logic    use_imm;
        alu_op_e alu_op;
        logic    mem_we;
        logic    wb_mem;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode import sc_pkg::*; (
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        case (opcode)
            OP_RTYPE: begin
                if (funct == FN_ADD) begin
                    ctrl.legal     = 1'b1;
                    ctrl.reg_we    = 1'b1;
                    ctrl.dst_is_rd = 1'b1;
                end
            end
            OP_ADDI: begin
                ctrl.legal   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            OP_SLTI: begin
                ctrl.legal   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
            end
            OP_LW: begin
                ctrl.legal   = 1'b1;
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
            end
            OP_SW: begin
                ctrl.legal   = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu import sc_pkg::*; (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (op)
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter  int NREGS = 32,
    parameter  int W     = 32,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_dbg,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_d [NREGS];
    logic [W-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            regs_q[i] <= rst ? '0 : regs_d[i];
        end
    end

    assign rd_a   = regs_q[ra_a];
    assign rd_b   = regs_q[ra_b];
    assign rd_dbg = regs_q[ra_dbg];
endmodule

// File: rtl/sc_dmem.sv
module sc_dmem #(
    parameter  int WORDS = 64,
    parameter  int W     = 32,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  rdata,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] dbg_addr,
    output logic [W-1:0]  dbg_data
);
    logic [W-1:0] mem_d [WORDS];
    logic [W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            mem_q[i] <= rst ? '0 : mem_d[i];
        end
    end

    assign rdata    = mem_q[addr];
    assign dbg_data = mem_q[dbg_addr];
endmodule

// File: rtl/sc_core.sv
module sc_core import sc_pkg::*; #(
    parameter  int IMEM_WORDS = 64,
    parameter  int DMEM_WORDS = 64,
    localparam int IA_W       = $clog2(IMEM_WORDS),
    localparam int DA_W       = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [IA_W-1:0] ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [4:0]      dbg_reg_sel,
    output logic [XLEN-1:0] dbg_reg_val,
    input  logic [DA_W-1:0] dbg_mem_sel,
    output logic [XLEN-1:0] dbg_mem_val,
    output logic [XLEN-1:0] pc
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t        st_d, st_q;
    logic [XLEN-1:0] imem_d [IMEM_WORDS];
    logic [XLEN-1:0] imem_q [IMEM_WORDS];

    logic [XLEN-1:0]   instr, imm_sx, rs_val, rt_val, alu_b, alu_y, mem_rd, wb_data;
    logic [5:0]        opcode, funct;
    logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    ctrl_t             ctrl;

    // next-state: program counter and instruction store
    always_comb begin
        st_d    = st_q;
        st_d.pc = st_q.pc + 32'd4;
        imem_d  = imem_q;
        if (ld_en) begin
            imem_d[ld_addr] = ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        imem_q <= imem_d;
    end

    // fetch and field split
    assign instr  = imem_q[st_q.pc[IA_W+1:2]];
    assign opcode = instr[31:26];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign funct  = instr[5:0];
    assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    sc_regfile #(.NREGS(NREG), .W(XLEN)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_a   (rs_idx),
        .ra_b   (rt_idx),
        .ra_dbg (dbg_reg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_reg_val),
        .we     (ctrl.reg_we),
        .wa     (wr_idx),
        .wd     (wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rt_val;

    sc_alu u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    sc_dmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk      (clk),
        .rst      (rst),
        .addr     (alu_y[DA_W+1:2]),
        .rdata    (mem_rd),
        .we       (ctrl.mem_we),
        .wdata    (rt_val),
        .dbg_addr (dbg_mem_sel),
        .dbg_data (dbg_mem_val)
    );

    assign wr_idx  = ctrl.dst_is_rd ? rd_idx : rt_idx;
    assign wb_data = ctrl.wb_mem ? mem_rd : alu_y;
    assign pc      = st_q.pc;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk import sc_pkg::*; (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [5:0]      opcode,
    input logic [5:0]      funct,
    input ctrl_t           ctrl,
    input logic [4:0]      rs_idx,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] wb_data
);
    logic known;
    assign known = (opcode == OP_RTYPE && funct == FN_ADD) || opcode == OP_ADDI ||
                   opcode == OP_SLTI || opcode == OP_LW || opcode == OP_SW;

    p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc == '0));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (pc == $past(pc) + 32'd4));

    p_slti_bool_r5: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_SLTI) |-> (wb_data[XLEN-1:1] == '0));

    p_lw_path_r6: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_LW) |-> (ctrl.wb_mem && ctrl.reg_we && !ctrl.mem_we));

    p_sw_noreg_r7: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_SW) |-> (ctrl.mem_we && !ctrl.reg_we));

    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == 5'd0) |-> (rs_val == '0));

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!ctrl.reg_we && !ctrl.mem_we));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pc      (pc),
    .opcode  (opcode),
    .funct   (funct),
    .ctrl    (ctrl),
    .rs_idx  (rs_idx),
    .rs_val  (rs_val),
    .wb_data (wb_data)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
    localparam int CLK_PERIOD = 1000;
    localparam int IW = 64;
    localparam int DW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_val;
    logic [5:0]  dbg_mem_sel = '0;
    logic [31:0] dbg_mem_val;
    logic [31:0] pc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] prog  [IW];
    logic [31:0] ref_r [32];
    logic [31:0] ref_m [DW];

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core u_dut (
        .clk (clk), .rst (rst), .ld_en (ld_en), .ld_addr (ld_addr), .ld_data (ld_data),
        .dbg_reg_sel (dbg_reg_sel), .dbg_reg_val (dbg_reg_val),
        .dbg_mem_sel (dbg_mem_sel), .dbg_mem_val (dbg_mem_val), .pc (pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input int i);
        dbg_reg_sel = i[4:0];
        #1;
        chk($sformatf("%s reg%0d", tag, i), dbg_reg_val, ref_r[i]);
    endtask

    task automatic chk_mem(input string tag, input int i);
        dbg_mem_sel = i[5:0];
        #1;
        chk($sformatf("%s mem%0d", tag, i), dbg_mem_val, ref_m[i]);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 32; i++) chk_reg(tag, i);
        for (int i = 0; i < DW; i++) chk_mem(tag, i);
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        logic [4:0] a = rs[4:0];
        logic [4:0] b = rt[4:0];
        logic [4:0] c = rd[4:0];
        return {6'h00, a, b, c, 5'h00, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        logic [4:0]  a = rs[4:0];
        logic [4:0]  b = rt[4:0];
        logic [15:0] k = imm[15:0];
        return {op, a, b, k};
    endfunction

    // reference model, built from the requirements; returns a kind code
    // 0 unknown, 1 add, 2 addi, 3 slti, 4 lw, 5 sw; dst and word index by output
    task automatic model_step(input logic [31:0] w, output int kind, output int dst, output int widx);
        logic [5:0]  op = w[31:26];
        int          rs = int'(w[25:21]);
        int          rt = int'(w[20:16]);
        int          rd = int'(w[15:11]);
        logic [31:0] im = {{16{w[15]}}, w[15:0]};
        logic [31:0] ea = ref_r[rs] + im;
        logic [31:0] res = '0;
        kind = 0; dst = 0; widx = int'(ea[7:2]);
        case (op)
            6'h00: if (w[5:0] == 6'h20) begin kind = 1; dst = rd; res = ref_r[rs] + ref_r[rt]; end
            6'h08: begin kind = 2; dst = rt; res = ref_r[rs] + im; end
            6'h0A: begin kind = 3; dst = rt; res = ($signed(ref_r[rs]) < $signed(im)) ? 32'd1 : 32'd0; end
            6'h23: begin kind = 4; dst = rt; res = ref_m[widx]; end
            6'h2B: begin kind = 5; ref_m[widx] = ref_r[rt]; end
            default: kind = 0;
        endcase
        if (kind >= 1 && kind <= 4 && dst != 0) ref_r[dst] = res;
    endtask

    initial begin
        #(CLK_PERIOD * 1000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int p;
        for (int i = 0; i < IW; i++) prog[i] = 32'h0;
        for (int i = 0; i < 32; i++) ref_r[i] = '0;
        for (int i = 0; i < DW; i++) ref_m[i] = '0;
        prog[0]  = enc_i(6'h08, 0, 1, 5);
        prog[1]  = enc_i(6'h08, 0, 2, -3);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_i(6'h08, 0, 4, 32767);
        prog[4]  = enc_r(4, 4, 5, 6'h20);
        prog[5]  = enc_i(6'h08, 0, 9, -32768);
        prog[6]  = enc_r(9, 9, 10, 6'h20);
        prog[7]  = enc_i(6'h0A, 2, 6, -2);
        prog[8]  = enc_i(6'h0A, 1, 7, 5);
        prog[9]  = enc_i(6'h0A, 2, 8, 0);
        prog[10] = enc_i(6'h08, 0, 10, 16);
        prog[11] = enc_i(6'h2B, 0, 1, 8);
        prog[12] = enc_i(6'h2B, 0, 2, 12);
        prog[13] = enc_i(6'h2B, 10, 3, -4);
        prog[14] = enc_i(6'h23, 0, 11, 8);
        prog[15] = enc_i(6'h23, 10, 12, -4);
        prog[16] = enc_i(6'h23, 10, 13, 4);
        prog[17] = enc_i(6'h08, 1, 0, 7);
        prog[18] = enc_r(0, 1, 14, 6'h20);
        prog[19] = {6'h3F, 5'd1, 5'd14, 16'h1234};
        prog[20] = enc_r(1, 1, 14, 6'h22);
        p = 21;
        for (int k = 16; k < 32; k++) begin
            prog[p] = enc_i(6'h08, k - 1, k, k * 37 - 300);
            p++;
        end
        for (int j = 0; j < 16; j++) begin
            prog[p] = enc_i(6'h2B, 0, 16 + j, 64 + 4 * j);
            p++;
        end

        // load program while reset is held (R10)
        for (int i = 0; i < IW; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = i[5:0]; ld_data = prog[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        chk("R1 pc", pc, 32'h0);
        sweep("R1 reset");

        rst = 1'b0;
        for (int i = 0; i < IW; i++) begin
            int kind, dst, widx;
            model_step(prog[i], kind, dst, widx);
            @(posedge clk);
            @(negedge clk);
            chk("R2 pc", pc, 32'(4 * (i + 1)));
            case (kind)
                1: chk_reg(dst == 0 ? "R8" : "R3", dst);
                2: chk_reg(dst == 0 ? "R8" : "R4", dst);
                3: chk_reg("R5", dst);
                4: chk_reg("R6", dst);
                5: begin chk_mem("R7", widx); chk_reg("R7", int'(prog[i][20:16])); end
                default: sweep("R9");
            endcase
        end
        chk_reg("R8", 0);
        sweep("R10 final");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule